// File: doc/BRIEF.md
# Dual-Clock FIFO with Reserve Margin

This block moves data words from a write clock domain into a read clock domain whose clock has no fixed relation to the write clock. A producer presents a word with a write request and must hold off while the full flag is high. A consumer raises a read request while the empty flag is low and takes the word from a registered output on the next read-clock cycle. Storage is a small array with a power-of-two entry count. Each side keeps a binary pointer that is one bit wider than the address. That pointer is also held in Gray form, and the Gray form is the only value that crosses into the other domain.

A reserve margin of entries makes both flags conservative. The full flag rises while a number of slots equal to the reserve is still free. The empty flag stays high until more than the reserve is stored, so with a non-zero reserve the last few words wait until later words push them out. The number of synchronizer stages on each crossing is a parameter. Each side's control flops run on a gated clock that ticks only while that side has a request or is in reset. The gate is either a low-transparent latch gate or a plain enable, chosen by a parameter. The elaboration rejects a reserve that is not smaller than the depth.

Top module: `dcfifo_reserve`

## Requirements
- R1: After a domain's synchronous active-high reset, the read side shows `rd_empty`=1 and `rd_data`=0, and the write side shows `wr_full`=0.
- R2: Words leave the read port in the order they were accepted at the write port, with their values unchanged, including after the pointers wrap around the array more than once.
- R3: After a read is accepted on a `rd_clk` rising edge, the word appears on `rd_data` after that edge. `rd_data` holds its value in every cycle without an accepted read.
- R4: `wr_full` is 1 exactly when the free entries (depth minus stored words, as the write side sees it) are at or below RESERVE. It rises on the `wr_clk` edge that accepts the write reaching depth minus RESERVE stored words.
- R5: `rd_empty` is 1 exactly when the stored count seen by the read side is at or below RESERVE. It rises on the `rd_clk` edge of the read that leaves RESERVE words stored.
- R6: A write request while `wr_full`=1 is ignored. The write pointer does not move and no stored word changes, so the FIFO holds the same number of words afterwards.
- R7: A read request while `rd_empty`=1 is ignored. The read pointer does not move and `rd_data` keeps its value.
- R8: Each pointer crosses domains as a Gray code that changes in at most one bit per cycle of its own clock. A stored word is never exceeded: the occupancy seen by either side never exceeds the depth.
- R9: Once reads have freed space, `wr_full` falls within SYNC_STAGES+3 `wr_clk` cycles after the last read.
- R10: A side's control state (pointer and, on the read side, `rd_data`) does not change in any cycle in which that side's request and reset are both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write domain clock |
| wr_rst | input | 1 | Write domain synchronous reset, active high |
| wr_req | input | 1 | Write request; accepted when `wr_full` is 0 |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | Free space at or below the reserve |
| rd_clk | input | 1 | Read domain clock |
| rd_rst | input | 1 | Read domain synchronous reset, active high |
| rd_req | input | 1 | Read request; accepted when `rd_empty` is 0 |
| rd_data | output | DATA_W | Registered word from the last accepted read |
| rd_empty | output | 1 | Stored count at or below the reserve |

## Verification
The assertions check several rules on every cycle. Requests against a raised flag must leave the pointers and `rd_data` untouched. A Gray pointer may change in only one bit per cycle, occupancy on both sides must stay within the depth, and an idle side's state must hold. Other behaviours only the bench scenarios can show. These are the order and values of the words after several wraps and the exact edge where each flag rises under a reserve of one. They also include the stuck reserve word that only a later write releases, and the delayed release of full once the read pointer has crossed the synchronizer.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;

    // How a side's control clock is stopped while that side is idle.
    typedef enum logic {
        GATE_REG   = 1'b0,   // clock passes through, flops use enable terms
        GATE_LATCH = 1'b1    // low-transparent latch gate on the clock
    } gate_mode_e;

    // Gray encoding of a binary count.
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Binary value of a Gray code, for a code of the given width.
    function automatic logic [31:0] from_gray(input logic [31:0] g, input int w);
        logic [31:0] b;
        b = '0;
        for (int i = 31; i >= 0; i--) begin
            if (i < w) begin
                b[i] = g[i] ^ ((i == w - 1) ? 1'b0 : b[i + 1]);
            end
        end
        return b;
    endfunction

endpackage

// File: rtl/dcf_clk_gate.sv
`timescale 1ns/1ps
module dcf_clk_gate
    import dcf_pkg::*;
#(
    parameter gate_mode_e MODE = GATE_REG
) (
    input  logic clk,
    input  logic en,
    output logic gclk
);

    generate
        if (MODE == GATE_LATCH) begin : g_latch
            logic en_lat;
            // Enable is captured while the clock is low, so the gated
            // clock never carries a shortened high phase.
            always_latch begin
                if (!clk) en_lat = en;
            end
            assign gclk = clk & en_lat;
        end else begin : g_pass
            logic unused_en;
            assign unused_en = en;
            assign gclk      = clk;
        end
    endgenerate

endmodule

// File: rtl/dcf_ptr_sync.sv
`timescale 1ns/1ps
module dcf_ptr_sync
    import dcf_pkg::*;
#(
    parameter int PW     = 4,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);

    logic [PW-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= gray_in;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= stg[s-1];
            end
        end
    endgenerate

    logic [31:0] bin_wide;
    always_comb begin
        bin_wide = from_gray(32'(stg[STAGES-1]), PW);
        bin_out  = bin_wide[PW-1:0];
    end

    logic [31:0] unused_hi;
    assign unused_hi = {bin_wide[31:PW], {PW{1'b0}}};

endmodule

// File: rtl/dcf_mem.sv
`timescale 1ns/1ps
module dcf_mem #(
    parameter int DW = 8,
    parameter int AW = 3,
    localparam int DEPTH = 1 << AW
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] arr [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) arr[waddr] <= wdata;
    end

    assign rdata = arr[raddr];

endmodule

// File: rtl/dcf_wr_ctl.sv
`timescale 1ns/1ps
module dcf_wr_ctl
    import dcf_pkg::*;
#(
    parameter int AW      = 3,
    parameter int RESERVE = 0,
    localparam int PW     = AW + 1,
    localparam int DEPTH  = 1 << AW
) (
    input  logic          clk,
    input  logic          gclk,
    input  logic          rst,
    input  logic          req,
    input  logic [PW-1:0] rbin_sync,
    output logic          full,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray
);

    logic [PW-1:0] wbin, wbin_nx, used;
    logic [31:0]   gray_nx;

    always_comb begin
        used    = wbin - rbin_sync;           // modulo 2*DEPTH
        full    = (used >= PW'(DEPTH - RESERVE));
        we      = req & ~full;
        wbin_nx = wbin + 1'b1;
        gray_nx = to_gray(32'(wbin_nx));
        waddr   = wbin[AW-1:0];
    end

    always_ff @(posedge gclk) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (we) begin
            wbin  <= wbin_nx;
            wgray <= gray_nx[PW-1:0];
        end
    end

    // R6
    wr_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (req && full) |=> $stable(wbin));
    // R8
    wr_gray_step_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(wgray ^ $past(wgray)) <= 1);
    // R8
    wr_used_bound_chk: assert property (@(posedge clk) disable iff (rst)
        used <= PW'(DEPTH));
    // R10
    wr_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req |=> $stable(wbin));

endmodule

// File: rtl/dcf_rd_ctl.sv
`timescale 1ns/1ps
module dcf_rd_ctl
    import dcf_pkg::*;
#(
    parameter int AW      = 3,
    parameter int DW      = 8,
    parameter int RESERVE = 0,
    localparam int PW     = AW + 1,
    localparam int DEPTH  = 1 << AW
) (
    input  logic          clk,
    input  logic          gclk,
    input  logic          rst,
    input  logic          req,
    input  logic [PW-1:0] wbin_sync,
    input  logic [DW-1:0] mem_rdata,
    output logic          empty,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output logic [DW-1:0] rd_data
);

    logic [PW-1:0] rbin, rbin_nx, stored;
    logic [31:0]   gray_nx;
    logic          take;

    always_comb begin
        stored  = wbin_sync - rbin;           // modulo 2*DEPTH
        empty   = (stored <= PW'(RESERVE));
        take    = req & ~empty;
        rbin_nx = rbin + 1'b1;
        gray_nx = to_gray(32'(rbin_nx));
        raddr   = rbin[AW-1:0];
    end

    always_ff @(posedge gclk) begin
        if (rst) begin
            rbin    <= '0;
            rgray   <= '0;
            rd_data <= '0;
        end else if (take) begin
            rbin    <= rbin_nx;
            rgray   <= gray_nx[PW-1:0];
            rd_data <= mem_rdata;
        end
    end

    // R7
    rd_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (req && empty) |=> ($stable(rbin) && $stable(rd_data)));
    // R8
    rd_gray_step_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(rgray ^ $past(rgray)) <= 1);
    // R8
    rd_stored_bound_chk: assert property (@(posedge clk) disable iff (rst)
        stored <= PW'(DEPTH));
    // R10
    rd_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req |=> ($stable(rbin) && $stable(rd_data)));

endmodule

// File: rtl/dcfifo_reserve.sv
`timescale 1ns/1ps
module dcfifo_reserve
    import dcf_pkg::*;
#(
    parameter int         DATA_W      = 8,
    parameter int         ADDR_W      = 3,
    parameter int         SYNC_STAGES = 2,
    parameter int         RESERVE     = 0,
    parameter gate_mode_e GATE_MODE   = GATE_REG
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int PW    = ADDR_W + 1;

    generate
        if (RESERVE < 0 || RESERVE >= DEPTH) begin : g_bad_reserve
            $error("dcfifo_reserve: RESERVE must lie in 0 .. DEPTH-1");
        end
        if (SYNC_STAGES < 2) begin : g_bad_sync
            $error("dcfifo_reserve: SYNC_STAGES must be at least 2");
        end
    endgenerate

    logic              wr_gclk, rd_gclk;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr, mem_raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic [PW-1:0]     wgray, rgray, wbin_at_rd, rbin_at_wr;

    dcf_clk_gate #(.MODE(GATE_MODE)) u_wgate (
        .clk (wr_clk),
        .en  (wr_req | wr_rst),
        .gclk(wr_gclk)
    );

    dcf_clk_gate #(.MODE(GATE_MODE)) u_rgate (
        .clk (rd_clk),
        .en  (rd_req | rd_rst),
        .gclk(rd_gclk)
    );

    dcf_wr_ctl #(.AW(ADDR_W), .RESERVE(RESERVE)) u_wctl (
        .clk      (wr_clk),
        .gclk     (wr_gclk),
        .rst      (wr_rst),
        .req      (wr_req),
        .rbin_sync(rbin_at_wr),
        .full     (wr_full),
        .we       (mem_we),
        .waddr    (mem_waddr),
        .wgray    (wgray)
    );

    dcf_rd_ctl #(.AW(ADDR_W), .DW(DATA_W), .RESERVE(RESERVE)) u_rctl (
        .clk      (rd_clk),
        .gclk     (rd_gclk),
        .rst      (rd_rst),
        .req      (rd_req),
        .wbin_sync(wbin_at_rd),
        .mem_rdata(mem_rdata),
        .empty    (rd_empty),
        .raddr    (mem_raddr),
        .rgray    (rgray),
        .rd_data  (rd_data)
    );

    // Read pointer into the write domain, write pointer into the read domain.
    dcf_ptr_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk    (wr_clk),
        .rst    (wr_rst),
        .gray_in(rgray),
        .bin_out(rbin_at_wr)
    );

    dcf_ptr_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk    (rd_clk),
        .rst    (rd_rst),
        .gray_in(wgray),
        .bin_out(wbin_at_rd)
    );

    dcf_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
        .wclk (wr_gclk),
        .we   (mem_we),
        .waddr(mem_waddr),
        .wdata(wr_data),
        .raddr(mem_raddr),
        .rdata(mem_rdata)
    );

endmodule

// File: tb/tb_dcfifo_reserve.sv
`timescale 1ns/1ps
module tb_dcfifo_reserve;
    import dcf_pkg::*;

    localparam int DW      = 8;
    localparam int AW      = 3;
    localparam int STAGES  = 3;
    localparam int RSV     = 1;
    localparam int DEPTH   = 1 << AW;
    localparam int NSTREAM = 20;

    localparam logic [DW-1:0] VEC [DEPTH-RSV] =
        '{8'h11, 8'h22, 8'h3C, 8'h4D, 8'hA5, 8'h96, 8'h7E};

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          wr_rst = 1'b1, rd_rst = 1'b1;
    logic          wr_req = 1'b0, rd_req = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_full, rd_empty;
    logic [DW-1:0] rd_data;

    int total = 0;
    int bad   = 0;

    always #2.5 wr_clk = ~wr_clk;   // 200 MHz write clock
    always #3.7 rd_clk = ~rd_clk;   // unrelated read clock

    dcfifo_reserve #(
        .DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(STAGES),
        .RESERVE(RSV), .GATE_MODE(GATE_LATCH)
    ) dut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_req(wr_req), .wr_data(wr_data),
        .wr_full(wr_full), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_req(rd_req),
        .rd_data(rd_data), .rd_empty(rd_empty)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_req  = 1'b1;
        wr_data = d;
        @(negedge wr_clk);
        wr_req  = 1'b0;
    endtask

    task automatic pop();
        @(negedge rd_clk);
        rd_req = 1'b1;
        @(negedge rd_clk);
        rd_req = 1'b0;
    endtask

    task automatic reset_both();
        wr_rst = 1'b1;
        rd_rst = 1'b1;
        wr_req = 1'b0;
        rd_req = 1'b0;
        repeat (STAGES + 3) @(negedge rd_clk);
        @(negedge wr_clk) wr_rst = 1'b0;
        @(negedge rd_clk) rd_rst = 1'b0;
        repeat (2) @(negedge rd_clk);
    endtask

    function automatic logic [DW-1:0] stream_val(input int k);
        return DW'(k * 7 + 3);
    endfunction

    initial begin
        repeat (100000) @(posedge wr_clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        reset_both();
        @(negedge rd_clk);
        chk("R1 rd_empty after reset", 32'(rd_empty), 32'd1);
        chk("R1 rd_data after reset", 32'(rd_data), 32'd0);
        @(negedge wr_clk);
        chk("R1 wr_full after reset", 32'(wr_full), 32'd0);

        // R7: reads against an empty FIFO
        @(negedge rd_clk) rd_req = 1'b1;
        repeat (3) @(negedge rd_clk);
        rd_req = 1'b0;
        chk("R7 rd_data held on empty read", 32'(rd_data), 32'd0);
        chk("R7 rd_empty still high", 32'(rd_empty), 32'd1);

        // Table walk: fill to the reserve boundary (R4)
        for (int i = 0; i < DEPTH - RSV; i++) begin
            push(VEC[i]);
            if (i == DEPTH - RSV - 2) chk("R4 wr_full low one before limit", 32'(wr_full), 32'd0);
        end
        chk("R4 wr_full high at depth-reserve", 32'(wr_full), 32'd1);

        // R6: write while full is dropped
        push(8'hEE);
        chk("R6 wr_full still high", 32'(wr_full), 32'd1);

        // R10: write side idle, flag holds
        repeat (10) @(negedge wr_clk);
        chk("R10 wr_full steady while idle", 32'(wr_full), 32'd1);

        repeat (STAGES + 6) @(negedge rd_clk);
        chk("R5 rd_empty low with data", 32'(rd_empty), 32'd0);

        // Table walk: drain to the reserve (R2, R3, R5)
        for (int i = 0; i < DEPTH - RSV - 1; i++) begin
            pop();
            chk($sformatf("R2 R3 word %0d", i), 32'(rd_data), 32'(VEC[i]));
            if (i == DEPTH - RSV - 3) chk("R5 rd_empty low with reserve+1", 32'(rd_empty), 32'd0);
        end
        chk("R5 rd_empty high at reserve", 32'(rd_empty), 32'd1);

        repeat (5) @(negedge rd_clk);
        chk("R3 rd_data holds with no read", 32'(rd_data), 32'(VEC[DEPTH-RSV-2]));
        pop();
        chk("R7 read at reserve ignored", 32'(rd_data), 32'(VEC[DEPTH-RSV-2]));

        // R9: full releases after the read pointer crosses
        repeat (STAGES + 3) @(negedge wr_clk);
        chk("R9 wr_full released", 32'(wr_full), 32'd0);

        // Release the reserve word; a stored 8'hEE would show up here (R6)
        push(8'h5A);
        repeat (STAGES + 6) @(negedge rd_clk);
        chk("R5 rd_empty low after extra write", 32'(rd_empty), 32'd0);
        pop();
        chk("R2 reserve word released", 32'(rd_data), 32'(VEC[DEPTH-RSV-1]));
        chk("R6 no extra word stored", 32'(rd_empty), 32'd1);

        // R2: streaming across several pointer wraps
        fork
            begin
                int k = 0;
                while (k < NSTREAM) begin
                    @(negedge wr_clk);
                    if (!wr_full) begin
                        wr_req  = 1'b1;
                        wr_data = stream_val(k);
                        @(negedge wr_clk);
                        wr_req  = 1'b0;
                        k++;
                    end
                end
            end
            begin
                int got = 0;
                while (got < NSTREAM) begin
                    @(negedge rd_clk);
                    if (!rd_empty) begin
                        rd_req = 1'b1;
                        @(negedge rd_clk);
                        rd_req = 1'b0;
                        chk($sformatf("R2 stream word %0d", got), 32'(rd_data),
                            32'((got == 0) ? 8'h5A : stream_val(got - 1)));
                        got++;
                    end
                end
            end
        join

        // R1: reset in the middle of operation
        reset_both();
        @(negedge rd_clk);
        chk("R1 rd_empty after second reset", 32'(rd_empty), 32'd1);
        @(negedge wr_clk);
        chk("R1 wr_full after second reset", 32'(wr_full), 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule